// File: doc/BRIEF.md
# Cascaded Two-Group DMA Priority Arbiter

This block decides which of eight DMA channel slots is served next. The slots form two groups of four. The low group holds channels 0 to 3 and the high group holds channels 4 to 7. Channel 4 is reserved as the link between the groups. The high group treats any pending low-group request as a single request in slot 4. When slot 4 wins, the grant goes to whichever low-group channel won inside its own group. So seven channels (0–3 and 5–7) can actually be granted.

A channel requests service in two ways: through its hardware request line, or through a software request bit. A one-cycle set pulse latches the software bit, and it stays set until the channel reaches terminal count while it is granted. Both kinds of request pass through the same mask and the same priority logic. Each group picks its winner in one of two ways, selected by its own mode bit:
- **Fixed order:** the lowest local index has the highest priority.
- **Rotating order:** the search starts just after the last channel that group served.

The sequencing is a two-state machine:
- **IDLE:** the arbiter evaluates requests on every clock. With at least one eligible request, the transition IDLE→GRANT registers the winner.
- **GRANT:** the one-hot acknowledge is held, and the machine stays in GRANT until the transfer-done strobe.
- **GRANT→IDLE:** taken on the transfer-done strobe. Arbitration runs again on the following clock.

With no eligible request, IDLE stays in IDLE.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, `dack` is all zero, `grant_valid` is 0, no software request is pending, and a group in rotating mode ranks its local index 0 highest at its first arbitration.
- R2: The eligible request of channel c (c ≠ 4) is (`dreq[c]` OR software bit c) AND NOT `chan_mask[c]`. For channel 4, `dreq[4]`, software bit 4 and `chan_mask[4]` have no effect on any grant.
- R3: A pulse on `sw_req_set[c]` latches a software request for channel c. The request persists across grants until `tc` is high in a GRANT cycle whose granted channel is c, and it then clears.
- R4: A group whose mode bit is 0 (`rot_en[0]` for the low group, `rot_en[1]` for the high group) grants its lowest requesting local index.
- R5: A group whose mode bit is 1 searches its slots upward, wrapping around, starting at the local index after the one it last granted.
- R6: The high group sees slot 4 as requested whenever any low-group channel is eligible. Slot 4 is high-group local index 0, so in fixed mode any eligible low channel beats channels 5 to 7.
- R7: `dack` is one-hot or zero, and `dack[4]` is never 1. When `grant_valid` is 1, `dack` has bit `grant_ch` set.
- R8: If eligible requests exist at a rising edge in IDLE, the grant appears after that edge. It then holds unchanged whatever the requests do, until the first edge with `xfer_done` high. After that edge `grant_valid` is 0 for at least one cycle.
- R9: The last-granted pointers update when a grant is issued. A low-group grant sets the high group's pointer to slot 4 and the low group's pointer to that channel. A grant to channels 5 to 7 updates only the high group's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq | input | 8 | Hardware request per channel |
| sw_req_set | input | 8 | One-cycle pulses that latch software requests |
| chan_mask | input | 8 | 1 blocks the channel's requests |
| rot_en | input | 2 | Priority mode per group: bit 0 low, bit 1 high; 1 = rotating |
| tc | input | 1 | Terminal count of the granted channel |
| xfer_done | input | 1 | End of the active transfer; releases the grant |
| dack | output | 8 | One-hot channel acknowledge |
| grant_valid | output | 1 | A grant is active |
| grant_ch | output | 3 | Number of the granted channel |

## Verification
The hardest situation to reach from the ports is a rotating priority state several grants deep in both groups at once. In that state the high group's pointer sits on slot 4 while the low group's pointer sits on some other channel. The bench sweeps all 256 request patterns under each of the four mode combinations without resetting between patterns. This lets the pointers drift through every combination, and a running arithmetic model of both pointers predicts each winner. Software-bit persistence and clearing are reached by latching a bit while every channel is masked, then releasing grants with and without terminal count.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } arb_state_e;

endpackage

// File: rtl/dma_req_merge.sv
module dma_req_merge #(
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned CASCADE_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] dreq,
    input  logic [NUM_CH-1:0] sw_set,
    input  logic [NUM_CH-1:0] sw_clr,
    input  logic [NUM_CH-1:0] chan_mask,
    output logic [NUM_CH-1:0] eff_req
);

    localparam logic [NUM_CH-1:0] CAS_BIT = NUM_CH'(1) << CASCADE_CH;

    logic [NUM_CH-1:0] sw_q;

    // software request latch: set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else begin
            sw_q <= (sw_q & ~sw_clr) | sw_set;
        end
    end

    // hardware and software requests merged, then masked; cascade slot never user-requestable
    always_comb begin
        eff_req = (dreq | sw_q) & ~chan_mask & ~CAS_BIT;
    end

    // a set pulse must be visible in the latch on the next cycle
    assert_swset_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_set) |=> ((sw_q & $past(sw_set)) == $past(sw_set)));

    // a cleared bit without a concurrent set must be gone on the next cycle
    assert_swclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_clr & ~sw_set)) |=> ((sw_q & $past(sw_clr & ~sw_set)) == '0));

endmodule

// File: rtl/dma_group_prio.sv
module dma_group_prio #(
    parameter int unsigned GRP_SIZE = 4,
    localparam int unsigned IDXW    = $clog2(GRP_SIZE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GRP_SIZE-1:0] req,
    input  logic                rotate,
    input  logic                upd,
    input  logic [IDXW-1:0]     upd_idx,
    output logic                any,
    output logic [IDXW-1:0]     win
);

    // GRP_SIZE must be a power of two so the index wraps naturally
    logic [IDXW-1:0]     last_q;
    logic [IDXW-1:0]     start_idx;
    logic [IDXW-1:0]     probe;
    logic [GRP_SIZE-1:0] below_win;

    // last-serviced pointer; reset to the top index so rotation begins at 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IDXW'(GRP_SIZE - 1);
        end else if (upd) begin
            last_q <= upd_idx;
        end
    end

    // circular search from the start index
    always_comb begin
        start_idx = rotate ? (last_q + IDXW'(1)) : '0;
        any       = 1'b0;
        win       = '0;
        probe     = '0;
        for (int k = 0; k < int'(GRP_SIZE); k++) begin
            probe = start_idx + IDXW'(k);
            if (!any && req[probe]) begin
                any = 1'b1;
                win = probe;
            end
        end
    end

    assign below_win = (GRP_SIZE'(1) << win) - GRP_SIZE'(1);

    assert_win_requests_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[win]);

    assert_fixed_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (any && !rotate) |-> ((req & below_win) == '0));

    assert_any_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any == (|req));

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int unsigned GRP_SIZE = 4,
    localparam int unsigned NUM_CH  = 2 * GRP_SIZE,
    localparam int unsigned CHW     = $clog2(NUM_CH),
    localparam int unsigned IDXW    = $clog2(GRP_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] dreq,
    input  logic [NUM_CH-1:0] sw_req_set,
    input  logic [NUM_CH-1:0] chan_mask,
    input  logic [1:0]        rot_en,
    input  logic              tc,
    input  logic              xfer_done,
    output logic [NUM_CH-1:0] dack,
    output logic              grant_valid,
    output logic [CHW-1:0]    grant_ch
);

    localparam int unsigned CASCADE_CH = GRP_SIZE;

    arb_state_e          state_q, state_d;
    logic [NUM_CH-1:0]   eff_req;
    logic [NUM_CH-1:0]   sw_clr;
    logic [GRP_SIZE-1:0] grp_req [2];
    logic [1:0]          grp_any;
    logic [IDXW-1:0]     grp_win [2];
    logic [1:0]          grp_upd;
    logic                start_grant;
    logic [CHW-1:0]      pick_ch;
    logic [CHW-1:0]      grant_ch_q;

    // terminal count in a grant cycle clears the granted channel's software bit
    assign sw_clr = (state_q == ST_GRANT && tc) ? dack : '0;

    dma_req_merge #(
        .NUM_CH     (NUM_CH),
        .CASCADE_CH (CASCADE_CH)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .dreq      (dreq),
        .sw_set    (sw_req_set),
        .sw_clr    (sw_clr),
        .chan_mask (chan_mask),
        .eff_req   (eff_req)
    );

    // low group sees its own channels; high group sees the cascade slot at index 0
    assign grp_req[0] = eff_req[GRP_SIZE-1:0];
    assign grp_req[1] = eff_req[NUM_CH-1:GRP_SIZE] | GRP_SIZE'(|eff_req[GRP_SIZE-1:0]);

    assign start_grant = (state_q == ST_IDLE) && grp_any[1];
    assign grp_upd[1]  = start_grant;
    assign grp_upd[0]  = start_grant && (grp_win[1] == '0);

    for (genvar g = 0; g < 2; g++) begin : g_group
        dma_group_prio #(
            .GRP_SIZE (GRP_SIZE)
        ) u_prio (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (grp_req[g]),
            .rotate  (rot_en[g]),
            .upd     (grp_upd[g]),
            .upd_idx (grp_win[g]),
            .any     (grp_any[g]),
            .win     (grp_win[g])
        );
    end

    // cascade slot winning hands the grant to the low group's winner
    assign pick_ch = (grp_win[1] == '0) ? CHW'(grp_win[0])
                                        : CHW'(GRP_SIZE) + CHW'(grp_win[1]);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (grp_any[1]) state_d = ST_GRANT;
            ST_GRANT: if (xfer_done)  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register: channel captured when a grant is issued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_ch_q <= '0;
        end else if (start_grant) begin
            grant_ch_q <= pick_ch;
        end
    end

    assign grant_valid = (state_q == ST_GRANT);
    assign grant_ch    = grant_ch_q;
    assign dack        = grant_valid ? (NUM_CH'(1) << grant_ch_q) : '0;

    assert_dack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack) && !dack[CASCADE_CH]);

    assert_grant_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !xfer_done) |=> (grant_valid && $stable(grant_ch)));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && xfer_done) |=> !grant_valid);

    assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (|($past(eff_req) & dack)));

endmodule

// File: tb/dma_prio_arb_tb_top.sv
`timescale 1ns/1ps
module dma_prio_arb_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] dreq, sw_req_set, chan_mask;
    logic [1:0] rot_en;
    logic       tc, xfer_done;
    logic [7:0] dack;
    logic       grant_valid;
    logic [2:0] grant_ch;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int         last_lo = 3;
    int         last_hi = 3;
    logic [7:0] sw_model = 8'h00;

    always #10 clk = ~clk;

    dma_prio_arb dut_i (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .sw_req_set(sw_req_set),
        .chan_mask(chan_mask), .rot_en(rot_en), .tc(tc), .xfer_done(xfer_done),
        .dack(dack), .grant_valid(grant_valid), .grant_ch(grant_ch)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pick(logic [3:0] r, bit rot, int last);
        int s;
        s = rot ? (last + 1) % 4 : 0;
        for (int k = 0; k < 4; k++) begin
            if (r[(s + k) % 4]) return (s + k) % 4;
        end
        return -1;
    endfunction

    // reference: expected channel from merged requests and bench pointers (R2, R4, R5, R6)
    function automatic int expect_ch(logic [7:0] dr, logic [7:0] mk, logic [1:0] rot);
        logic [7:0] eff;
        logic [3:0] hi;
        int hw;
        eff = (dr | sw_model) & ~mk & 8'hEF;
        hi  = {eff[7:5], |eff[3:0]};
        hw  = pick(hi, rot[1], last_hi);
        if (hw < 0) return -1;
        if (hw == 0) return pick(eff[3:0], rot[0], last_lo);
        return 4 + hw;
    endfunction

    // one arbitration: apply, check grant, optional hold, release with optional tc
    task automatic trial(logic [7:0] dr, logic [7:0] mk, logic [1:0] rot,
                         bit with_tc, int hold, string tag);
        int ch;
        logic [7:0] eff;
        logic [7:0] held;
        ch  = expect_ch(dr, mk, rot);
        eff = (dr | sw_model) & ~mk & 8'hEF;
        dreq = dr; chan_mask = mk; rot_en = rot;
        @(posedge clk);
        @(negedge clk);
        if (ch < 0) begin
            check({tag, " no grant"}, {23'd0, grant_valid, dack}, 32'd0);
        end else begin
            string t;
            if (ch < 4 && eff[7:5] != 3'b000) t = "R6";
            else if ((ch < 4 && rot[0]) || (ch > 4 && rot[1])) t = "R5";
            else t = "R4";
            check({tag, " ", t, " dack"}, {24'd0, dack}, 32'd1 << ch);
            check({tag, " R7 grant_ch"}, {28'd0, grant_valid, grant_ch}, {28'd1, 3'(ch)});
            if (ch < 4) begin last_lo = ch; last_hi = 0; end   // R9
            else last_hi = ch - 4;
            held = dack;
            for (int h = 0; h < hold; h++) begin
                dreq = ~dreq;
                @(posedge clk);
                @(negedge clk);
                check({tag, " R8 hold"}, {24'd0, dack}, {24'd0, held});
            end
            xfer_done = 1'b1; tc = with_tc;
            @(posedge clk);
            @(negedge clk);
            if (with_tc) sw_model[ch] = 1'b0;
            check({tag, " R8 release gap"}, {31'd0, grant_valid}, 32'd0);
        end
        xfer_done = 1'b0; tc = 1'b0; dreq = 8'h00; chan_mask = 8'hFF;
    endtask

    // latch software bits while everything is masked (R3)
    task automatic sw_pulse(logic [7:0] v);
        chan_mask = 8'hFF;
        sw_req_set = v;
        @(posedge clk);
        @(negedge clk);
        sw_req_set = 8'h00;
        sw_model = sw_model | v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dreq = 8'h00; sw_req_set = 8'h00; chan_mask = 8'hFF;
        rot_en = 2'b00; tc = 1'b0; xfer_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset dack", {24'd0, dack}, 32'd0);
        check("R1 reset valid", {31'd0, grant_valid}, 32'd0);
        rst_n = 1'b1;
        // R1: unmasked, no requests -> no pending software bit produces a grant
        chan_mask = 8'h00;
        @(posedge clk);
        @(negedge clk);
        check("R1 no pending sw", {31'd0, grant_valid}, 32'd0);
        chan_mask = 8'hFF;
        // R1/R5: rotating after reset starts at local index 0
        trial(8'hEF, 8'h00, 2'b11, 1'b0, 0, "R1");
        check("R1 first rotate ch0", {29'd0, 3'(last_lo)}, 32'd0);

        // R2: channel 4 request and mask have no effect
        trial(8'h10, 8'h00, 2'b00, 1'b0, 0, "R2 dreq4");
        trial(8'h30, 8'h10, 2'b00, 1'b0, 0, "R2 mask4");
        trial(8'h22, 8'h02, 2'b00, 1'b0, 0, "R2 mask blocks");

        // R8: grant held through request changes
        trial(8'h81, 8'h00, 2'b00, 1'b0, 3, "R8");

        // R3: software request persists without tc, clears with tc
        sw_pulse(8'h40);
        trial(8'h00, 8'h00, 2'b00, 1'b0, 0, "R3 sw first");
        trial(8'h00, 8'h00, 2'b00, 1'b1, 0, "R3 sw persists");
        trial(8'h00, 8'h00, 2'b00, 1'b0, 0, "R3 sw cleared");
        // R2/R3: mask blocks software request; bit 4 ignored
        sw_pulse(8'h12);
        trial(8'h00, 8'h02, 2'b00, 1'b0, 0, "R2 sw masked");
        trial(8'h00, 8'h00, 2'b00, 1'b1, 0, "R3 sw low");
        trial(8'h00, 8'h00, 2'b00, 1'b0, 0, "R2 sw4 ignored");
        // R3: software and hardware compete on equal terms
        sw_pulse(8'h01);
        trial(8'h04, 8'h00, 2'b00, 1'b1, 0, "R3 sw vs hw");

        // near-exhaustive sweep: pointers carried across patterns (R4 R5 R6 R9)
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 256; p++) begin
                logic [7:0] mk;
                mk = ((p * 37) % 5 == 0) ? 8'(p * 73) : 8'h00;
                trial(8'(p), mk, 2'(m), 1'b0, 0, "SWEEP");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule